// File: doc/BRIEF.md
# Multi-Channel Shadowed PWM Generator

This block drives a set of independent pulse-width-modulated outputs. Software programs it through a small memory-mapped register bus. One shared control word holds an enable bit for each channel. Three alias addresses change that word atomically: one sets the written bits, one clears them and one toggles them. Each channel has two registers. The threshold register holds the count at which the output leaves its active state. The timing register holds the period length, a 2-bit output code for each of the two states, and a prescaler select.

A channel counts prescaled ticks from 0 up to its period length minus one, then starts again at 0. The output takes the active-state level while the count is below the threshold and the idle-state level for the rest of the period. New settings never disturb a running period. Software writes the threshold register first, and that write is only held in a shadow copy. Software then writes the timing register, which arms the channel. The armed shadow set is copied into the working registers as one unit when the running counter wraps. If the channel is disabled, the copy happens on the next cycle instead.

The register bus is a plain write strobe with a combinational read port. Every write is accepted in the cycle it is presented, so the bus has no back-pressure and needs no valid/ready handshake.

Top module: `pwm_bank`

## Requirements
- R1: After reset the control word, every threshold and timing register, the prescaler divider and all outputs are 0, and every register address reads 0.
- R2: Writing address 0x0 loads the control word from write-data bits [NUM_CH-1:0]. Bit n enables channel n, and the other write-data bits are dropped. Address 0x0 and each of its three aliases read back the control word, zero-extended.
- R3: A write to 0x4 ORs the write data into the control word, a write to 0xC XORs it in, and a write to 0x8 clears every bit that is 1 in the write data. Bits not named in the write keep their value.
- R4: Channel n's threshold register is at 0x10 + 0x20*n and stores only write-data bits [31:16]. Its timing register is at 0x20 + 0x20*n and stores only bits [22:0]: period length in [15:0], active-state code in [17:16], idle-state code in [19:18] and prescaler select in [22:20]. Bits that are not stored read back as 0.
- R5: A level code of 3 drives the output high. Codes 2, 1 and 0 drive it low.
- R6: An enabled channel advances its count once per tick through 0 … period−1 and then returns to 0. A period of 0 holds the count at 0. The active-state level is shown while count < threshold, and also for the whole period when threshold ≥ period; otherwise the idle-state level is shown. The output is registered, so it shows the state of the count from the previous clock cycle.
- R7: A single free-running 10-bit divider starts at 0 after reset and advances every clock cycle. Select codes 0 to 7 give a shift s of 0, 1, 2, 3, 4, 6, 8 and 10, and a channel ticks in every cycle in which the low s bits of the divider are all ones.
- R8: A threshold write changes only the shadow copy. A timing write stores the shadow timing value and arms the channel. An enabled, armed channel copies both shadow values into its working registers at the tick where its count wraps. Register reads always return the working values.
- R9: While a channel is disabled, its count is held at 0 and its output is 0. An armed, disabled channel commits its shadow values on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe; one write per cycle while high |
| bus_addr | input | ADDR_W | Byte address for writes and reads |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pwm_out | output | NUM_CH | Registered PWM outputs, bit n for channel n |

## Verification
The bench builds the block with its default of four channels and an 8-bit address, which puts the last timing register at 0x80 and covers the whole decoder. With four channels, one channel can run an inverted level pair, another the low-only codes and a third a threshold above its period, all at the same time, while the alias writes change several enable bits at once. The prescaler runs at select codes 5 and 7, so the slowest tick of 1024 cycles is checked in full against a cycle-by-cycle model of the outputs.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  // Data width of the register bus and the fixed field widths of the channel registers.
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;
  localparam int LVL_W  = 2;
  localparam int SEL_W  = 3;
  localparam int PRE_W  = 10;

  // Byte address layout of the register file.
  localparam int CTRL_ADDR  = 'h0;
  localparam int SET_ADDR   = 'h4;
  localparam int CLR_ADDR   = 'h8;
  localparam int TOG_ADDR   = 'hC;
  localparam int THR_BASE   = 'h10;
  localparam int TIM_BASE   = 'h20;
  localparam int CH_STRIDE  = 'h20;

  // Timing register contents; the first member sits in the most significant bits.
  typedef struct packed {
    logic [SEL_W-1:0] div_sel;
    logic [LVL_W-1:0] idle_lvl;
    logic [LVL_W-1:0] act_lvl;
    logic [CNT_W-1:0] period;
  } tim_cfg_t;

  localparam int CFG_W = $bits(tim_cfg_t);

  // Number of low divider bits that must be all ones for a tick.
  function automatic logic [3:0] sel_to_shift(input logic [SEL_W-1:0] sel);
    logic [3:0] s;
    case (sel)
      3'd5:    s = 4'd6;
      3'd6:    s = 4'd8;
      3'd7:    s = 4'd10;
      default: s = {1'b0, sel};
    endcase
    return s;
  endfunction

  // Only code 3 drives the pin high.
  function automatic logic lvl_is_high(input logic [LVL_W-1:0] code);
    return code == 2'b11;
  endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_CH-1:0][SEL_W-1:0]  sel_i,
  output logic [NUM_CH-1:0]             tick_o
);

  logic [PRE_W-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_tick
    logic [3:0]       shift;
    logic [PRE_W-1:0] mask;

    assign shift = sel_to_shift(sel_i[g]);

    always_comb begin
      mask = '0;
      for (int b = 0; b < PRE_W; b++) begin
        if (b < int'(shift)) mask[b] = 1'b1;
      end
    end

    assign tick_o[g] = (div_q & mask) == mask;
  end

endmodule

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [NUM_CH-1:0]             ctrl_wdata_i,
  input  tim_cfg_t [NUM_CH-1:0]         wrk_cfg_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  wrk_thr_i,
  output logic [NUM_CH-1:0]             ctrl_o,
  output logic [NUM_CH-1:0]             thr_we_o,
  output logic [NUM_CH-1:0]             tim_we_o,
  output logic [DATA_W-1:0]             rdata_o
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(SET_ADDR);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(CLR_ADDR);
  localparam logic [ADDR_W-1:0] A_TOG  = ADDR_W'(TOG_ADDR);

  logic [NUM_CH-1:0] ctrl_q;
  logic              hit_ctrl;

  assign hit_ctrl = (addr_i == A_CTRL) || (addr_i == A_SET) ||
                    (addr_i == A_CLR)  || (addr_i == A_TOG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (we_i) begin
      if (addr_i == A_CTRL)     ctrl_q <= ctrl_wdata_i;
      else if (addr_i == A_SET) ctrl_q <= ctrl_q | ctrl_wdata_i;
      else if (addr_i == A_CLR) ctrl_q <= ctrl_q & ~ctrl_wdata_i;
      else if (addr_i == A_TOG) ctrl_q <= ctrl_q ^ ctrl_wdata_i;
    end
  end

  assign ctrl_o = ctrl_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
    localparam logic [ADDR_W-1:0] THR_A = ADDR_W'(THR_BASE + g * CH_STRIDE);
    localparam logic [ADDR_W-1:0] TIM_A = ADDR_W'(TIM_BASE + g * CH_STRIDE);
    assign thr_we_o[g] = we_i && (addr_i == THR_A);
    assign tim_we_o[g] = we_i && (addr_i == TIM_A);
  end

  always_comb begin
    rdata_o = '0;
    if (hit_ctrl) rdata_o[NUM_CH-1:0] = ctrl_q;
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr_i == ADDR_W'(THR_BASE + c * CH_STRIDE))
        rdata_o = {wrk_thr_i[c], {(DATA_W-CNT_W){1'b0}}};
      if (addr_i == ADDR_W'(TIM_BASE + c * CH_STRIDE))
        rdata_o = {{(DATA_W-CFG_W){1'b0}}, wrk_cfg_i[c]};
    end
  end

  // R3: the set alias only adds bits
  assert_set_alias_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == A_SET) |=> ctrl_q == ($past(ctrl_q) | $past(ctrl_wdata_i)));

  // R3: the clear alias only removes bits
  assert_clr_alias_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == A_CLR) |=> ctrl_q == ($past(ctrl_q) & ~$past(ctrl_wdata_i)));

  // R2: without a write the control word holds
  assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(ctrl_q));

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              thr_we_i,
  input  logic              tim_we_i,
  input  logic [CNT_W-1:0]  thr_val_i,
  input  tim_cfg_t          tim_val_i,
  output tim_cfg_t          wrk_cfg_o,
  output logic [CNT_W-1:0]  wrk_thr_o,
  output logic              pwm_o
);

  tim_cfg_t         shd_cfg_q, wrk_cfg_q;
  logic [CNT_W-1:0] shd_thr_q, wrk_thr_q, cnt_q;
  logic             armed_q, out_q;
  logic             wrap, commit, in_act;
  logic [LVL_W-1:0] lvl;

  assign wrap   = ({1'b0, cnt_q} + 17'd1) >= {1'b0, wrk_cfg_q.period};
  assign commit = armed_q && (!en_i || (tick_i && wrap));
  assign in_act = (cnt_q < wrk_thr_q) || (wrk_thr_q >= wrk_cfg_q.period);
  assign lvl    = in_act ? wrk_cfg_q.act_lvl : wrk_cfg_q.idle_lvl;

  // Shadow stage and arm flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_cfg_q <= '0;
      shd_thr_q <= '0;
      armed_q   <= 1'b0;
    end else begin
      if (thr_we_i) shd_thr_q <= thr_val_i;
      if (tim_we_i) shd_cfg_q <= tim_val_i;
      if (tim_we_i)    armed_q <= 1'b1;
      else if (commit) armed_q <= 1'b0;
    end
  end

  // Working set, counter and registered output
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrk_cfg_q <= '0;
      wrk_thr_q <= '0;
      cnt_q     <= '0;
      out_q     <= 1'b0;
    end else begin
      if (commit) begin
        wrk_cfg_q <= shd_cfg_q;
        wrk_thr_q <= shd_thr_q;
      end
      if (!en_i)       cnt_q <= '0;
      else if (tick_i) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      out_q <= en_i && lvl_is_high(lvl);
    end
  end

  assign wrk_cfg_o = wrk_cfg_q;
  assign wrk_thr_o = wrk_thr_q;
  assign pwm_o     = out_q;

  // R9: a disabled channel drives 0 on the next cycle
  assert_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !pwm_o);

  // R9: a disabled channel keeps its count at 0
  assert_idle_cnt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> cnt_q == '0);

  // R8: the working set only changes when a period starts
  assert_commit_at_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((wrk_thr_q != $past(wrk_thr_q)) || (wrk_cfg_q != $past(wrk_cfg_q))) |-> cnt_q == '0);

  // R6: the count stays inside the period
  assert_cnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrk_cfg_q.period != '0) |-> cnt_q < wrk_cfg_q.period);

  // R5: a high output needs a code of 3 in one of the level fields
  assert_high_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_o |-> ($past(wrk_cfg_q.act_lvl) == 2'b11 || $past(wrk_cfg_q.idle_lvl) == 2'b11));

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);

  logic [NUM_CH-1:0]             ctrl;
  logic [NUM_CH-1:0]             thr_we, tim_we, tick;
  tim_cfg_t [NUM_CH-1:0]         wrk_cfg;
  logic [NUM_CH-1:0][CNT_W-1:0]  wrk_thr;
  logic [NUM_CH-1:0][SEL_W-1:0]  div_sel;

  pwm_regfile #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .we_i         (bus_we),
    .addr_i       (bus_addr),
    .ctrl_wdata_i (bus_wdata[NUM_CH-1:0]),
    .wrk_cfg_i    (wrk_cfg),
    .wrk_thr_i    (wrk_thr),
    .ctrl_o       (ctrl),
    .thr_we_o     (thr_we),
    .tim_we_o     (tim_we),
    .rdata_o      (bus_rdata)
  );

  pwm_prescaler #(
    .NUM_CH (NUM_CH)
  ) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_i  (div_sel),
    .tick_o (tick)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign div_sel[g] = wrk_cfg[g].div_sel;

    pwm_channel u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (ctrl[g]),
      .tick_i    (tick[g]),
      .thr_we_i  (thr_we[g]),
      .tim_we_i  (tim_we[g]),
      .thr_val_i (bus_wdata[31:16]),
      .tim_val_i (tim_cfg_t'(bus_wdata[CFG_W-1:0])),
      .wrk_cfg_o (wrk_cfg[g]),
      .wrk_thr_o (wrk_thr[g]),
      .pwm_o     (pwm_out[g])
    );
  end

endmodule

// File: tb/pwm_bank_tb_top.sv
`timescale 1ns/1ps
module pwm_bank_tb_top;

  localparam int NCH = 4;
  localparam int AW  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NCH-1:0] pwm;

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #2 clk = ~clk;

  pwm_bank #(.NUM_CH(NCH), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .pwm_out(pwm)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model and scoreboard queue ----------------
  function automatic int shift_of(input logic [2:0] s);
    int tbl[8] = '{0, 1, 2, 3, 4, 6, 8, 10};
    return tbl[s];
  endfunction

  int            m_pre;
  logic [NCH-1:0] m_ctrl;
  logic [15:0]   m_cnt[NCH], m_wthr[NCH], m_sthr[NCH];
  logic [22:0]   m_wcfg[NCH], m_scfg[NCH];
  bit            m_arm[NCH];
  logic [NCH-1:0] exp_q[$];

  always @(posedge clk) begin
    logic [NCH-1:0] nout;
    logic [15:0] per;
    logic [1:0]  lv;
    bit          act_st, tk, wr;
    int          sh;
    if (!rst_n) begin
      m_pre = 0;
      m_ctrl = '0;
      for (int c = 0; c < NCH; c++) begin
        m_cnt[c] = 0; m_wthr[c] = 0; m_sthr[c] = 0;
        m_wcfg[c] = 0; m_scfg[c] = 0; m_arm[c] = 0;
      end
      exp_q.delete();
    end else begin
      for (int c = 0; c < NCH; c++) begin
        per = m_wcfg[c][15:0];
        act_st = (m_cnt[c] < m_wthr[c]) || (m_wthr[c] >= per);
        lv = act_st ? m_wcfg[c][17:16] : m_wcfg[c][19:18];
        nout[c] = m_ctrl[c] && (lv == 2'b11);
        sh = shift_of(m_wcfg[c][22:20]);
        tk = (m_pre % (1 << sh)) == ((1 << sh) - 1);
        wr = 1'b0;
        if (!m_ctrl[c]) begin
          m_cnt[c] = 0;
          wr = 1'b1;
        end else if (tk) begin
          if (int'(m_cnt[c]) + 1 >= int'(per)) begin
            m_cnt[c] = 0;
            wr = 1'b1;
          end else begin
            m_cnt[c] = m_cnt[c] + 1;
          end
        end
        if (wr && m_arm[c]) begin
          m_wcfg[c] = m_scfg[c];
          m_wthr[c] = m_sthr[c];
          m_arm[c] = 1'b0;
        end
        if (we && addr == AW'(16 + 32 * c)) m_sthr[c] = wdata[31:16];
        if (we && addr == AW'(32 + 32 * c)) begin
          m_scfg[c] = wdata[22:0];
          m_arm[c] = 1'b1;
        end
      end
      if (we) begin
        case (addr)
          8'h00: m_ctrl = wdata[NCH-1:0];
          8'h04: m_ctrl = m_ctrl | wdata[NCH-1:0];
          8'h08: m_ctrl = m_ctrl & ~wdata[NCH-1:0];
          8'h0C: m_ctrl = m_ctrl ^ wdata[NCH-1:0];
          default: ;
        endcase
      end
      m_pre++;
      exp_q.push_back(nout);
    end
  end

  // monitor: compare outputs away from the active edge
  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      logic [NCH-1:0] e;
      e = exp_q.pop_front();
      chk(pwm == e, cur_req, 32'(pwm), 32'(e));
    end
  end

  // ---------------- driver tasks ----------------
  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    addr = a;
    #1;
    chk(rdata == exp, req, rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] tcfg(input int per, input int act, input int idl, input int dv);
    return (32'(dv) << 20) | (32'(idl) << 18) | (32'(act) << 16) | 32'(per);
  endfunction

  // ---------------- stimulus ----------------
  initial begin
    int hi;
    idle(5);
    rst_n = 1'b1;
    // R1: reset state
    cur_req = "R1";
    rd_chk(8'h00, 0, "R1");
    rd_chk(8'h10, 0, "R1");
    rd_chk(8'h20, 0, "R1");
    rd_chk(8'h80, 0, "R1");
    chk(pwm == 0, "R1", 32'(pwm), 0);

    // configure all channels while disabled (R4, R9)
    cur_req = "R9";
    wr_reg(8'h10, 32'd3 << 16);
    wr_reg(8'h20, tcfg(8, 3, 2, 0));
    wr_reg(8'h30, 32'd7 << 16);
    wr_reg(8'h40, tcfg(5, 3, 2, 0));
    wr_reg(8'h50, (32'd2 << 16) | 32'h0000_BEEF);
    wr_reg(8'h60, 32'hFF80_0000 | tcfg(6, 2, 3, 0));
    wr_reg(8'h70, 32'd2 << 16);
    wr_reg(8'h80, tcfg(4, 0, 1, 1));
    idle(2);
    rd_chk(8'h20, tcfg(8, 3, 2, 0), "R9");
    rd_chk(8'h10, 32'd3 << 16, "R9");
    rd_chk(8'h50, 32'd2 << 16, "R4");
    rd_chk(8'h60, tcfg(6, 2, 3, 0), "R4");
    rd_chk(8'h80, tcfg(4, 0, 1, 1), "R4");

    // R2 / R3: control word and its aliases
    cur_req = "R2";
    wr_reg(8'h00, 32'hFFFF_FFF1);
    rd_chk(8'h00, 32'h1, "R2");
    rd_chk(8'h04, 32'h1, "R2");
    cur_req = "R3";
    wr_reg(8'h04, 32'h6);
    rd_chk(8'h00, 32'h7, "R3");
    wr_reg(8'h0C, 32'h9);
    rd_chk(8'h0C, 32'hE, "R3");
    wr_reg(8'h08, 32'h2);
    rd_chk(8'h08, 32'hC, "R3");
    wr_reg(8'h04, 32'h3);
    rd_chk(8'h00, 32'hF, "R3");

    // R5 / R6: run all four patterns against the model
    cur_req = "R6";
    idle(40);
    cur_req = "R5";
    idle(20);

    // R8: staging while running
    cur_req = "R8";
    wr_reg(8'h10, 32'd6 << 16);
    rd_chk(8'h10, 32'd3 << 16, "R8");
    wr_reg(8'h20, tcfg(10, 3, 2, 0));
    rd_chk(8'h20, tcfg(8, 3, 2, 0), "R8");
    rd_chk(8'h10, 32'd3 << 16, "R8");
    idle(25);
    rd_chk(8'h20, tcfg(10, 3, 2, 0), "R8");
    rd_chk(8'h10, 32'd6 << 16, "R8");

    // R6: duty over whole periods, counted at the pin
    hi = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (pwm[0]) hi++;
    end
    chk(hi == 60, "R6", 32'(hi), 60);

    // R7: prescaler codes 5 and 7
    cur_req = "R7";
    wr_reg(8'h08, 32'h8);
    wr_reg(8'h70, 32'd1 << 16);
    wr_reg(8'h80, tcfg(2, 3, 2, 5));
    idle(2);
    wr_reg(8'h04, 32'h8);
    idle(300);
    wr_reg(8'h08, 32'h8);
    wr_reg(8'h80, tcfg(2, 3, 2, 7));
    idle(2);
    wr_reg(8'h04, 32'h8);
    idle(4200);

    // R9: disable everything
    cur_req = "R9";
    wr_reg(8'h08, 32'hF);
    idle(3);
    chk(pwm == 0, "R9", 32'(pwm), 0);
    rd_chk(8'h00, 32'h0, "R9");
    idle(10);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule